// File: doc/BRIEF.md
# Fast Link Pulse Auto-Negotiation Engine

This block advertises the local speed and duplex abilities on a single-bit pulse line and learns the abilities of the link partner from the same kind of pulse line. Each burst it sends has 33 pulse positions. Every even position always holds a clock pulse. Every odd position carries one bit of a 16-bit code word: a pulse means 1, and no pulse means 0. A new burst starts at a fixed repetition interval. A divider turns the system clock into ticks, and all timing is counted in those ticks.

The receiver locks onto the partner's clock pulses. It uses tolerance windows to decide whether each data position holds a 1. A partner word counts as settled after it arrives three times in a row. Once that happens, the block sets the acknowledge bit in its own outgoing word. When the settled partner word also carries the acknowledge bit, the block picks the highest mode that both sides support and reports it. If no mode is shared, it raises a failure flag instead. The result is held until reset, and no software is involved at any point.

Top module: `flp_autoneg`

## Requirements
- R1: A transmitted burst has 33 pulse positions spaced SLOT_TICKS*TICK_DIV clock cycles apart. A one-cycle clock pulse appears at each of the 17 even positions (0, 2, ..., 32), and no two pulses are on adjacent cycles.
- R2: Bit i of the outgoing word is sent at position 2i+1, where a pulse means 1. The word layout is: bits [4:0] = 5'b00001 (selector), bit 5 = 10 Mb/s half duplex, bit 6 = 10 Mb/s full duplex, bit 7 = 100 Mb/s half duplex, bit 8 = 100 Mb/s full duplex (taken from adv_abil_i[0..3]), bit 14 = acknowledge, and all other bits 0.
- R3: Transmitted bursts begin every BURST_SLOTS*SLOT_TICKS*TICK_DIV clock cycles. The first burst starts right after reset.
- R4: After a received clock pulse, a pulse within SLOT_TICKS/4 ticks of one slot is a 1 data bit. A pulse within the same tolerance of two slots is the next clock. A pulse anywhere else aborts the burst, and the partial word is discarded.
- R5: When a correct-selector partner word has arrived in three consecutive complete bursts, the acknowledge bit is set in every outgoing word from the next burst onward. It stays set until reset.
- R6: A received word whose selector is not 5'b00001 is ignored. It neither counts toward the three matches nor breaks a run of matches.
- R7: When the settled partner word has its acknowledge bit set, the common abilities (local AND partner) are resolved in this order: 100 full, 100 half, 10 full, 10 half. The block then asserts link_ready_o, with speed_100_o and full_duplex_o describing the chosen mode.
- R8: If no ability is common, no_common_o is asserted and link_ready_o, speed_100_o and full_duplex_o stay low.
- R9: While in reset and just after it, every result output and flp_tx_o are low.
- R10: Once a result (ready or failure) is reported, later partner words leave all result outputs unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_abil_i | input | 4 | Local abilities: [0] 10 half, [1] 10 full, [2] 100 half, [3] 100 full |
| flp_rx_i | input | 1 | Received pulse line, one cycle per pulse |
| flp_tx_o | output | 1 | Transmitted pulse line, one cycle per pulse |
| link_ready_o | output | 1 | A common mode was chosen |
| speed_100_o | output | 1 | Chosen mode runs at 100 Mb/s |
| full_duplex_o | output | 1 | Chosen mode is full duplex |
| no_common_o | output | 1 | Negotiation ended with no shared ability |

## Verification
The bench builds the block with TICK_DIV=2, SLOT_TICKS=8 and BURST_SLOTS=40. This gives a 16-cycle slot, a 640-cycle burst period and a two-tick window margin, so a complete three-word exchange fits in a couple of thousand cycles and many resets and scenarios fit in one run. Because a tick is only two cycles, shifting data pulses by up to two cycles lands them inside the tolerance window. A stray pulse eight cycles after a clock lands clearly outside both windows, which exercises the abort path.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int WORD_W    = 16;
  localparam int BURST_POS = 33;
  localparam int ABIL_W    = 4;
  localparam int ABIL_LSB  = 5;
  localparam int ACK_BIT   = 14;
  localparam logic [4:0] SELECTOR = 5'b00001;

  typedef enum logic {RX_IDLE, RX_RUN} rx_state_e;

  typedef struct packed {
    logic ok;
    logic spd100;
    logic fdx;
  } mode_t;

  // common[3]=100F, [2]=100H, [1]=10F, [0]=10H
  function automatic mode_t pick_mode(input logic [ABIL_W-1:0] common);
    mode_t m;
    m = '0;
    if (common[3])      m = '{ok: 1'b1, spd100: 1'b1, fdx: 1'b1};
    else if (common[2]) m = '{ok: 1'b1, spd100: 1'b1, fdx: 1'b0};
    else if (common[1]) m = '{ok: 1'b1, spd100: 1'b0, fdx: 1'b1};
    else if (common[0]) m = '{ok: 1'b1, spd100: 1'b0, fdx: 1'b0};
    return m;
  endfunction
endpackage

// File: rtl/flp_tick_gen.sv
module flp_tick_gen #(
  parameter int DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/flp_burst_tx.sv
module flp_burst_tx
  import flp_pkg::*;
#(
  parameter int SLOT_TICKS  = 50,
  parameter int BURST_SLOTS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pulse_o
);
  localparam int SW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int PW = $clog2(BURST_SLOTS);

  logic [SW-1:0]     slot_q;
  logic [PW-1:0]     pos_q;
  logic [WORD_W-1:0] word_q;
  logic              at_pos, in_burst, data_bit;

  assign at_pos   = tick_i && (slot_q == '0);
  assign in_burst = (pos_q < PW'(BURST_POS));
  assign data_bit = word_q[pos_q[4:1]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      pos_q   <= '0;
      word_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= at_pos && in_burst && (!pos_q[0] || data_bit);
      // word is frozen at the first clock so a mid-burst change cannot tear it
      if (at_pos && pos_q == '0) word_q <= word_i;
      if (tick_i) begin
        if (slot_q == SW'(SLOT_TICKS - 1)) begin
          slot_q <= '0;
          pos_q  <= (pos_q == PW'(BURST_SLOTS - 1)) ? '0 : pos_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flp_burst_rx.sv
module flp_burst_rx
  import flp_pkg::*;
#(
  parameter int SLOT_TICKS = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pulse_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int WIN     = SLOT_TICKS / 4;
  localparam int DATA_LO = SLOT_TICKS - WIN;
  localparam int DATA_HI = SLOT_TICKS + WIN;
  localparam int CLK_LO  = 2 * SLOT_TICKS - WIN;
  localparam int CLK_HI  = 2 * SLOT_TICKS + WIN;
  localparam int CNT_MAX = CLK_HI + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [3:0]        bits_q;
  logic              dseen_q;
  logic [WORD_W-1:0] sr_q;
  logic              in_data, in_clk;

  assign in_data = (cnt_q >= CW'(DATA_LO)) && (cnt_q <= CW'(DATA_HI));
  assign in_clk  = (cnt_q >= CW'(CLK_LO))  && (cnt_q <= CW'(CLK_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      dseen_q <= 1'b0;
      sr_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && cnt_q != CW'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          if (pulse_i) begin
            state_q <= RX_RUN;
            cnt_q   <= '0;
            bits_q  <= '0;
            dseen_q <= 1'b0;
          end
        end
        RX_RUN: begin
          if (pulse_i) begin
            if (in_data && !dseen_q) begin
              dseen_q <= 1'b1;
            end else if (in_clk) begin
              sr_q    <= {dseen_q, sr_q[WORD_W-1:1]};
              cnt_q   <= '0;
              dseen_q <= 1'b0;
              bits_q  <= bits_q + 1'b1;
              if (bits_q == 4'd15) begin
                valid_o <= 1'b1;
                word_o  <= {dseen_q, sr_q[WORD_W-1:1]};
                state_q <= RX_IDLE;
              end
            end else begin
              state_q <= RX_IDLE;  // off-window pulse: drop partial word
            end
          end else if (cnt_q > CW'(CLK_HI)) begin
            state_q <= RX_IDLE;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flp_arbiter.sv
module flp_arbiter
  import flp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ABIL_W-1:0] local_abil_i,
  output logic              ack_o,
  output logic              ready_o,
  output logic              spd100_o,
  output logic              fdx_o,
  output logic              fail_o
);
  logic [1:0]        match_q, match_n;
  logic [WORD_W-1:0] last_q;
  logic              ack_q, done_q;
  mode_t             res_q, mode;
  logic              sel_ok, same, hit;

  always_comb begin
    sel_ok  = (word_i[4:0] == SELECTOR);
    same    = (word_i == last_q) && (match_q != 2'd0);
    match_n = !same ? 2'd1 : (match_q == 2'd3) ? 2'd3 : match_q + 2'd1;
    hit     = word_valid_i && sel_ok && (match_n == 2'd3);
    mode    = pick_mode(local_abil_i & word_i[ABIL_LSB +: ABIL_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      last_q  <= '0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      if (word_valid_i && sel_ok) begin
        match_q <= match_n;
        last_q  <= word_i;
      end
      if (hit) ack_q <= 1'b1;
      if (hit && word_i[ACK_BIT] && !done_q) begin
        done_q <= 1'b1;
        res_q  <= mode;
      end
    end
  end

  assign ack_o    = ack_q;
  assign ready_o  = done_q && res_q.ok;
  assign fail_o   = done_q && !res_q.ok;
  assign spd100_o = res_q.spd100;
  assign fdx_o    = res_q.fdx;
endmodule

// File: rtl/flp_autoneg.sv
module flp_autoneg
  import flp_pkg::*;
#(
  parameter int TICK_DIV    = 125,
  parameter int SLOT_TICKS  = 50,
  parameter int BURST_SLOTS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ABIL_W-1:0] adv_abil_i,
  input  logic              flp_rx_i,
  output logic              flp_tx_o,
  output logic              link_ready_o,
  output logic              speed_100_o,
  output logic              full_duplex_o,
  output logic              no_common_o
);
  logic              tick;
  logic              ack_sent;
  logic              rx_valid;
  logic [WORD_W-1:0] rx_word, tx_word;

  assign tx_word = {1'b0, ack_sent, 5'b0, adv_abil_i, SELECTOR};

  flp_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  flp_burst_tx #(.SLOT_TICKS(SLOT_TICKS), .BURST_SLOTS(BURST_SLOTS)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .word_i(tx_word), .pulse_o(flp_tx_o)
  );

  flp_burst_rx #(.SLOT_TICKS(SLOT_TICKS)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .pulse_i(flp_rx_i),
    .word_o(rx_word), .valid_o(rx_valid)
  );

  flp_arbiter i_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_valid_i(rx_valid), .word_i(rx_word),
    .local_abil_i(adv_abil_i), .ack_o(ack_sent), .ready_o(link_ready_o),
    .spd100_o(speed_100_o), .fdx_o(full_duplex_o), .fail_o(no_common_o)
  );
endmodule

// File: rtl/flp_autoneg_chk.sv
module flp_autoneg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] adv_abil_i,
  input logic       flp_tx_o,
  input logic       link_ready_o,
  input logic       speed_100_o,
  input logic       full_duplex_o,
  input logic       no_common_o,
  input logic       ack_i
);
  p_tx_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flp_tx_o |=> !flp_tx_o);

  p_ack_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_i);

  p_fast_needs_local_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ready_o && speed_100_o) |-> (adv_abil_i[3] || adv_abil_i[2]));

  p_result_needs_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ready_o || no_common_o) |-> ack_i);

  p_fail_no_link_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_common_o |-> (!link_ready_o && !speed_100_o && !full_duplex_o));

  p_quiet_unresolved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_ready_o || no_common_o) |-> (!speed_100_o && !full_duplex_o));

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ready_o || no_common_o) |=>
      $stable({link_ready_o, speed_100_o, full_duplex_o, no_common_o}));
endmodule

bind flp_autoneg flp_autoneg_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adv_abil_i(adv_abil_i), .flp_tx_o(flp_tx_o),
  .link_ready_o(link_ready_o), .speed_100_o(speed_100_o),
  .full_duplex_o(full_duplex_o), .no_common_o(no_common_o), .ack_i(ack_sent)
);

// File: tb/test_flp_autoneg.sv
module test_flp_autoneg;
  localparam int TD = 2, ST = 8, BS = 40;
  localparam int SD = TD * ST;
  localparam int GAP = 3 * SD;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b0;
  logic [3:0] adv = 4'hf;
  logic tx, ready, spd, fdx, fail;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  flp_autoneg #(.TICK_DIV(TD), .SLOT_TICKS(ST), .BURST_SLOTS(BS)) i_flp_autoneg (
    .clk_i(clk), .rst_ni(rst_n), .adv_abil_i(adv), .flp_rx_i(rx), .flp_tx_o(tx),
    .link_ready_o(ready), .speed_100_o(spd), .full_duplex_o(fdx), .no_common_o(fail)
  );

  // transmit monitor
  int cyc = 0, last_p = -1000, t0 = 0, prev_t0 = -1;
  int clocks = 0, misalign = 0, bursts = 0;
  int l_clocks = 0, l_misalign = 0, l_period = 0, cur_period = 0;
  logic [15:0] wmon = '0, l_word = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_p  = -1000;
      prev_t0 = -1;
    end else if (tx) begin
      if (cyc - last_p > GAP) begin
        cur_period = (prev_t0 < 0) ? 0 : cyc - prev_t0;
        prev_t0 = cyc; t0 = cyc; wmon = '0; clocks = 1; misalign = 0;
      end else begin
        int p;
        p = (cyc - t0) / SD;
        if ((cyc - t0) % SD != 0) misalign++;
        if (p % 2 == 1) wmon[p/2] = 1'b1;
        else clocks++;
        if (p == 32) begin
          l_word = wmon; l_clocks = clocks; l_misalign = misalign;
          l_period = cur_period; bursts++;
        end
      end
      last_p = cyc;
    end
  end

  function automatic logic [15:0] fmt(input logic [3:0] ab, input logic ack);
    return {1'b0, ack, 5'b0, ab, 5'b00001};
  endfunction

  function automatic logic [3:0] exp_res(input logic [3:0] a, input logic [3:0] p);
    logic [3:0] c;
    c = a & p;
    if (c[3]) return 4'b1110;
    if (c[2]) return 4'b1100;
    if (c[1]) return 4'b1010;
    if (c[0]) return 4'b1000;
    return 4'b0001;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] a);
    @(posedge clk); #1;
    rst_n = 1'b0; rx = 1'b0; adv = a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic send_word(input logic [15:0] w, input int jit, input bit stray);
    for (int c = 0; c <= 32 * SD; c++) begin
      int p, off;
      p = c / SD; off = c % SD;
      @(posedge clk); #1;
      rx = ((p % 2 == 0) && off == 0) || ((p % 2 == 1) && w[p/2] && off == jit) ||
           (stray && c == SD / 2);
    end
    @(posedge clk); #1 rx = 1'b0;
    repeat (60) @(posedge clk);
  endtask

  task automatic wait_bursts(input int n);
    int b0;
    b0 = bursts;
    while (bursts < b0 + n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] res();
    return {ready, spd, fdx, fail};
  endfunction

  initial begin
    logic [3:0] held;
    void'($urandom(32'd2024));

    // R9 reset state
    do_reset(4'hf);
    @(negedge clk);
    check(res() == 4'b0 && tx == 1'b0, "R9", {res(), 3'b0, tx}, 0);

    // R1 R2 R3 burst format
    wait_bursts(3);
    check(l_clocks == 17, "R1 clocks", l_clocks, 17);
    check(l_misalign == 0, "R1 spacing", l_misalign, 0);
    check(l_word == fmt(4'hf, 1'b0), "R2 word", l_word, fmt(4'hf, 1'b0));
    check(l_period == BS * SD, "R3 period", l_period, BS * SD);

    // R5 ack after three matching words
    send_word(fmt(4'hf, 1'b0), 0, 1'b0);
    send_word(fmt(4'hf, 1'b0), 1, 1'b0);
    wait_bursts(2);
    check(l_word[14] == 1'b0, "R5 no ack after two", l_word[14], 0);
    send_word(fmt(4'hf, 1'b0), 2, 1'b0);
    wait_bursts(2);
    check(l_word == fmt(4'hf, 1'b1), "R5 ack word", l_word, fmt(4'hf, 1'b1));
    check(res() == 4'b0, "R7 waits partner ack", res(), 0);

    // R7 resolution with partner ack
    for (int k = 0; k < 3; k++) send_word(fmt(4'hf, 1'b1), k % 3, 1'b0);
    check(res() == 4'b1110, "R7 full match", res(), 4'b1110);

    // R10 hold after result
    held = res();
    for (int k = 0; k < 3; k++) send_word(fmt(4'b0001, 1'b1), 0, 1'b0);
    check(res() == held, "R10 hold", res(), held);

    // R6 wrong selector ignored
    do_reset(4'b0011);
    send_word(fmt(4'b0011, 1'b0), 0, 1'b0);
    send_word(fmt(4'b0011, 1'b0), 0, 1'b0);
    send_word({fmt(4'b0011, 1'b0)} ^ 16'h0003, 0, 1'b0);
    wait_bursts(2);
    check(l_word[14] == 1'b0, "R6 bad selector not counted", l_word[14], 0);
    send_word(fmt(4'b0011, 1'b0), 0, 1'b0);
    wait_bursts(2);
    check(l_word[14] == 1'b1, "R6 run not broken", l_word[14], 1);

    // R4 off-window pulse aborts
    do_reset(4'b0011);
    send_word(fmt(4'b0011, 1'b0), 0, 1'b0);
    send_word(fmt(4'b0011, 1'b0), 0, 1'b0);
    send_word(fmt(4'b0011, 1'b0), 0, 1'b1);
    wait_bursts(2);
    check(l_word[14] == 1'b0, "R4 aborted word dropped", l_word[14], 0);
    send_word(fmt(4'b0011, 1'b0), 2, 1'b0);
    wait_bursts(2);
    check(l_word[14] == 1'b1, "R4 jittered word accepted", l_word[14], 1);

    // R8 no common ability
    do_reset(4'b0101);
    for (int k = 0; k < 3; k++) send_word(fmt(4'b1010, 1'b1), 0, 1'b0);
    check(res() == 4'b0001, "R8 no common", res(), 4'b0001);

    // R7 directed priority cases and random mix
    for (int i = 0; i < 8; i++) begin
      logic [3:0] a, p;
      int j;
      case (i)
        0: begin a = 4'b0111; p = 4'b0110; end
        1: begin a = 4'b0011; p = 4'b1101; end
        2: begin a = 4'b1100; p = 4'b0111; end
        default: begin a = 4'($urandom); p = 4'($urandom); end
      endcase
      j = int'($urandom % 3);
      do_reset(a);
      for (int k = 0; k < 3; k++) send_word(fmt(p, 1'b1), j, 1'b0);
      check(res() == exp_res(a, p), "R7 priority", res(), exp_res(a, p));
      wait_bursts(2);
      check(l_word == fmt(a, 1'b1), "R5 R2 ack word", l_word, fmt(a, 1'b1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule